// File: doc/BRIEF.md
# Equality-Steered Branch Target Selector

This block is a small memory-mapped peripheral that lets a processor whose only instruction is a data move make conditional jumps. Software writes two candidate jump addresses and two operands into the block. A bus read of the block then returns one of the two addresses, depending on whether the operands match. When a program moves that read value into the program-counter location, it has executed a conditional branch. The decision is not a control signal. It is a data value that the block keeps ready to be read.

The block decodes a window of four consecutive word addresses starting at a base address (default 0xC100). The low two address bits pick the register for a write. A read anywhere in the window returns the selected target. Read data is combinational from the stored registers, so a value written at one clock edge is visible to a read in the cycle that follows. Outside a read hit, the read-data port is held at zero so it can be OR-combined onto a shared bus.

Top module: `branch_select_unit`

## Requirements
- R1: After reset all four registers hold zero, so a read in the window returns 0x0000 (the operands compare equal and target one is zero).
- R2: A write with the address inside the window loads write data into the register selected by the low two address bits: offset 0 is target one, offset 1 is target two, offset 2 is operand A, offset 3 is operand B. The register is updated at the clock edge on which the write is presented.
- R3: A read inside the window returns target one when operand A equals operand B in all 16 bits, including when both are all-ones.
- R4: A read inside the window returns target two when the operands differ in any bit, including a difference in a single bit at any of the 16 positions.
- R5: A read at any of the four window offsets returns the same selected target, and busRdHit is 1 during such a read.
- R6: When busRdEn is 0, or when the address lies outside the window, busRdData is 0x0000 and busRdHit is 0.
- R7: A write to an address outside the window changes none of the four registers. This includes addresses that share the low two bits with a window location.
- R8: A write inside the window leaves the three registers it does not address unchanged.
- R9: The comparison and selection are made at read time from the stored values, so a read in the cycle after an operand or target write already reflects it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Active-low synchronous reset |
| busAddr | input | 16 | Bus word address |
| busWrData | input | 16 | Data for a write |
| busWrEn | input | 1 | Write strobe, sampled at the clock edge |
| busRdEn | input | 1 | Read strobe, combinational |
| busRdData | output | 16 | Selected target during a read hit, else zero |
| busRdHit | output | 1 | High while a read falls inside the window |

## Verification
The bench sweeps operand pairs that differ in exactly one bit at each of the 16 positions. A comparator that checks only part of the word would then return target one for some of those pairs. All-ones and all-zero operand pairs catch a comparator that is inverted or reduced to a constant. Writes to addresses just outside the window, which share the low offset bits, catch a decoder that ignores the upper address bits by corrupting a register. Reads at every offset and reads with the strobe low catch wrong read gating, which would show up as a value or a hit flag where the bus must stay quiet.

// File: rtl/bsu_pkg.sv
package bsu_pkg;
  localparam int NUM_REGS = 4;
  localparam int OFF_W    = $clog2(NUM_REGS);

  // Register offsets: the read mux and the comparator depend on this order
  localparam int TGT_EQ = 0;
  localparam int TGT_NE = 1;
  localparam int OPND_A = 2;
  localparam int OPND_B = 3;

  typedef struct packed {
    logic [NUM_REGS-1:0] wrSel;
    logic                rdGate;
  } bsu_strobe_t;
endpackage

// File: rtl/bsu_decode.sv
module bsu_decode
  import bsu_pkg::*;
#(
  parameter int                ADDR_W    = 16,
  parameter logic [ADDR_W-1:0] BASE_ADDR = 16'hC100
) (
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busWrEn,
  input  logic              busRdEn,
  output bsu_strobe_t       strobe
);
  localparam logic [ADDR_W-OFF_W-1:0] WIN_TAG = BASE_ADDR[ADDR_W-1:OFF_W];

  logic             inWin;
  logic [OFF_W-1:0] offset;

  assign inWin  = (busAddr[ADDR_W-1:OFF_W] == WIN_TAG);
  assign offset = busAddr[OFF_W-1:0];

  for (genvar k = 0; k < NUM_REGS; k++) begin : g_wrsel
    assign strobe.wrSel[k] = busWrEn && inWin && (offset == OFF_W'(k));
  end

  assign strobe.rdGate = busRdEn && inWin;
endmodule

// File: rtl/bsu_regbank.sv
module bsu_regbank
  import bsu_pkg::*;
#(
  parameter int DATA_W = 16
) (
  input  logic                             clk,
  input  logic                             rstN,
  input  logic [NUM_REGS-1:0]              wrSel,
  input  logic [DATA_W-1:0]                wrData,
  output logic [NUM_REGS-1:0][DATA_W-1:0]  regView
);
  for (genvar k = 0; k < NUM_REGS; k++) begin : g_reg
    always_ff @(posedge clk) begin
      if (!rstN)         regView[k] <= '0;
      else if (wrSel[k]) regView[k] <= wrData;
    end
  end
endmodule

// File: rtl/bsu_select.sv
module bsu_select
  import bsu_pkg::*;
#(
  parameter int DATA_W = 16
) (
  input  logic [NUM_REGS-1:0][DATA_W-1:0] regView,
  input  logic                            rdGate,
  output logic [DATA_W-1:0]               rdData
);
  logic              opndMatch;
  logic [DATA_W-1:0] chosen;

  always_comb begin
    opndMatch = (regView[OPND_A] == regView[OPND_B]);
    chosen    = opndMatch ? regView[TGT_EQ] : regView[TGT_NE];
    rdData    = rdGate ? chosen : '0;
  end
endmodule

// File: rtl/branch_select_unit.sv
module branch_select_unit
  import bsu_pkg::*;
#(
  parameter int                ADDR_W    = 16,
  parameter int                DATA_W    = 16,
  parameter logic [ADDR_W-1:0] BASE_ADDR = 16'hC100
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [DATA_W-1:0] busWrData,
  input  logic              busWrEn,
  input  logic              busRdEn,
  output logic [DATA_W-1:0] busRdData,
  output logic              busRdHit
);
  bsu_strobe_t                     strobe;
  logic [NUM_REGS-1:0][DATA_W-1:0] regView;

  bsu_decode #(.ADDR_W(ADDR_W), .BASE_ADDR(BASE_ADDR)) u_decode (
    .busAddr (busAddr),
    .busWrEn (busWrEn),
    .busRdEn (busRdEn),
    .strobe  (strobe)
  );

  bsu_regbank #(.DATA_W(DATA_W)) u_regbank (
    .clk     (clk),
    .rstN    (rstN),
    .wrSel   (strobe.wrSel),
    .wrData  (busWrData),
    .regView (regView)
  );

  bsu_select #(.DATA_W(DATA_W)) u_select (
    .regView (regView),
    .rdGate  (strobe.rdGate),
    .rdData  (busRdData)
  );

  assign busRdHit = strobe.rdGate;
endmodule

// File: rtl/bsu_checker.sv
module bsu_checker
  import bsu_pkg::*;
#(
  parameter int                ADDR_W    = 16,
  parameter int                DATA_W    = 16,
  parameter logic [ADDR_W-1:0] BASE_ADDR = 16'hC100
) (
  input logic                            clk,
  input logic                            rstN,
  input logic [ADDR_W-1:0]               busAddr,
  input logic [DATA_W-1:0]               busWrData,
  input logic                            busWrEn,
  input logic                            busRdEn,
  input logic [DATA_W-1:0]               busRdData,
  input logic                            busRdHit,
  input logic [NUM_REGS-1:0][DATA_W-1:0] regView
);
  logic hitAddr;
  assign hitAddr = (busAddr >= BASE_ADDR) && (busAddr < BASE_ADDR + ADDR_W'(NUM_REGS));

  // R6: quiet bus outside a read hit
  a_r6_quiet_bus: assert property (@(posedge clk) disable iff (!rstN)
    !(busRdEn && hitAddr) |-> (busRdData == '0) && !busRdHit);

  // R5: every window offset produces a hit
  a_r5_window_hit: assert property (@(posedge clk) disable iff (!rstN)
    (busRdEn && hitAddr) |-> busRdHit);

  // R3: equal operands select target one
  a_r3_equal_pick: assert property (@(posedge clk) disable iff (!rstN)
    (busRdHit && regView[OPND_A] == regView[OPND_B]) |-> busRdData == regView[TGT_EQ]);

  // R4: unequal operands select target two
  a_r4_differ_pick: assert property (@(posedge clk) disable iff (!rstN)
    (busRdHit && regView[OPND_A] != regView[OPND_B]) |-> busRdData == regView[TGT_NE]);

  for (genvar k = 0; k < NUM_REGS; k++) begin : g_reg_chk
    // R2: addressed register takes the write data
    a_r2_load: assert property (@(posedge clk) disable iff (!rstN)
      (busWrEn && hitAddr && busAddr[OFF_W-1:0] == OFF_W'(k)) |=> regView[k] == $past(busWrData));
    // R7, R8: any other write leaves this register alone
    a_r8_untouched: assert property (@(posedge clk) disable iff (!rstN)
      !(busWrEn && hitAddr && busAddr[OFF_W-1:0] == OFF_W'(k)) |=> $stable(regView[k]));
  end
endmodule

bind branch_select_unit bsu_checker #(
  .ADDR_W(ADDR_W), .DATA_W(DATA_W), .BASE_ADDR(BASE_ADDR)
) u_chk (
  .clk(clk), .rstN(rstN), .busAddr(busAddr), .busWrData(busWrData),
  .busWrEn(busWrEn), .busRdEn(busRdEn), .busRdData(busRdData),
  .busRdHit(busRdHit), .regView(regView)
);

// File: tb/branch_select_unit_tb.sv
`timescale 1ns/1ps
module branch_select_unit_tb;
  localparam logic [15:0] BASE = 16'hC100;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [15:0] busAddr = '0;
  logic [15:0] busWrData = '0;
  logic        busWrEn = 1'b0;
  logic        busRdEn = 1'b0;
  logic [15:0] busRdData;
  logic        busRdHit;

  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  // bench model of register contents
  logic [15:0] mT1 = '0, mT2 = '0, mA = '0, mB = '0;

  always #4 clk = ~clk;

  branch_select_unit u_dut (
    .clk(clk), .rstN(rstN), .busAddr(busAddr), .busWrData(busWrData),
    .busWrEn(busWrEn), .busRdEn(busRdEn), .busRdData(busRdData), .busRdHit(busRdHit)
  );

  task automatic check(string req, logic [16:0] act, logic [16:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  task automatic busWrite(logic [15:0] addr, logic [15:0] data);
    @(negedge clk);
    busAddr = addr; busWrData = data; busWrEn = 1'b1; busRdEn = 1'b0;
    @(negedge clk);
    busWrEn = 1'b0;
    if (addr[15:2] == BASE[15:2]) begin
      case (addr[1:0])
        2'd0: mT1 = data;
        2'd1: mT2 = data;
        2'd2: mA  = data;
        default: mB = data;
      endcase
    end
  endtask

  function automatic logic [15:0] expSel();
    return (mA == mB) ? mT1 : mT2;
  endfunction

  task automatic busRead(logic [15:0] addr, string req);
    busAddr = addr; busRdEn = 1'b1;
    #1;
    check(req, {busRdHit, busRdData}, {1'b1, expSel()});
    busRdEn = 1'b0;
    #1;
  endtask

  task automatic quietRead(logic [15:0] addr, logic en);
    busAddr = addr; busRdEn = en;
    #1;
    check("R6", {busRdHit, busRdData}, 17'h0);
    busRdEn = 1'b0;
    #1;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R1: reset state
    busAddr = BASE; busRdEn = 1'b1; #1;
    check("R1", {busRdHit, busRdData}, {1'b1, 16'h0000});
    busRdEn = 1'b0;

    // R2: load each register and observe through the selection
    busWrite(BASE + 16'd0, 16'h1A2B);
    busWrite(BASE + 16'd1, 16'h3C4D);
    busRead(BASE, "R2");
    busWrite(BASE + 16'd2, 16'h0055);
    busRead(BASE, "R9");
    busWrite(BASE + 16'd3, 16'h0055);
    busRead(BASE, "R9");

    // R5: every offset returns the selection
    for (int o = 0; o < 4; o++) busRead(BASE + 16'(o), "R5");
    busWrite(BASE + 16'd3, 16'h0056);
    for (int o = 0; o < 4; o++) busRead(BASE + 16'(o), "R5");

    // R4 / R3: single-bit differences at every position, then equal
    for (int b = 0; b < 16; b++) begin
      logic [15:0] x;
      x = 16'((b * 16'h1111) ^ 16'hA5A5);
      busWrite(BASE + 16'd2, x);
      busWrite(BASE + 16'd3, x ^ (16'h1 << b));
      busRead(BASE, "R4");
      busWrite(BASE + 16'd3, x);
      busRead(BASE, "R3");
    end
    busWrite(BASE + 16'd2, 16'hFFFF);
    busWrite(BASE + 16'd3, 16'hFFFF);
    busRead(BASE + 16'd2, "R3");
    busWrite(BASE + 16'd3, 16'hFFFE);
    busRead(BASE + 16'd1, "R4");
    busWrite(BASE + 16'd3, 16'hFFFF);

    // R7: writes outside the window leave everything unchanged
    busWrite(16'hC104, 16'h0000);
    busWrite(16'hC0FF, 16'h1234);
    busWrite(16'h4100, 16'h9999);
    busWrite(16'hC102 ^ 16'h0100, 16'h7777);
    busRead(BASE, "R7");
    busWrite(BASE + 16'd3, 16'h0001);
    busWrite(16'hC0FE, 16'h0001);
    busRead(BASE, "R7");

    // R8: writing a target does not disturb the operands or the other target
    busWrite(BASE + 16'd0, 16'hBEEF);
    busRead(BASE, "R8");
    busWrite(BASE + 16'd3, 16'hFFFF);
    busRead(BASE, "R8");
    busWrite(BASE + 16'd1, 16'hCAFE);
    busRead(BASE + 16'd3, "R8");

    // R6: no read strobe or address outside the window
    @(negedge clk);
    quietRead(BASE, 1'b0);
    quietRead(16'hC104, 1'b1);
    quietRead(16'hC0FF, 1'b1);
    quietRead(16'h4100, 1'b1);

    if (!done) begin
      done = 1'b1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++; fails++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end
endmodule